// File: doc/BRIEF.md
# Command-Decoding SPI Memory Slave

This block is the serial front end of a radio-style peripheral. A host talks to it over a four-wire SPI link in mode 0, with the most significant bit first. The first byte of every transaction is an opcode. Depending on that opcode, the block does one of three things: it reads or writes a byte-wide internal memory through a 10-bit address space, it moves packet bytes to or from that memory starting at a base pointer, or it passes a one-byte command on to the radio controller.

While the opcode is shifting in, the block shifts out a status byte. That byte packs the controller's flags and state code. The two upper address bits are carried in the low bits of the opcode itself. Reads need a dummy byte before the data, and the block uses that time to fetch the first byte from its registered memory.

The SPI pins are brought into the system clock domain through synchronizer flops. The SPI clock must therefore run a good deal slower than the system clock.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, `miso` is low, `cmd_valid` is low, and no memory write takes place.
- R2: During the first byte of every transaction, MISO carries a status byte. Bit 7 is always 1 (interface ready). Bit 6 is `irq_pend`, bit 5 is `rc_ready`, bit 4 is `cca_clear`, and bits [3:0] are `rc_state`.
- R3: Opcode 0xFF (no operation) and any opcode not listed in R4 to R10 have no effect. Every byte after the status byte returns 0x00.
- R4: Opcode 0x18 plus address bits [9:8] starts a sequential write. The next byte is address bits [7:0], and each byte after that is written to the current address, which then increments.
- R5: Opcode 0x38 plus address bits [9:8] starts a sequential read. The next byte is address bits [7:0], then one dummy byte follows. The fourth and later bytes return memory data from consecutive addresses, and bytes 2 and 3 return 0x00.
- R6: Sequential addresses wrap from 0x3FF to 0x000.
- R7: Opcodes 0x08 (write) and 0x28 (read) plus address bits [9:8] use the same byte layout as R4 and R5, but the address never increments. Every data byte targets the one addressed location.
- R8: Opcode 0x10 writes the bytes that follow, from the second byte on, to consecutive addresses starting at `tx_base`.
- R9: Opcode 0x30 is followed by one dummy byte. From the third byte on, MISO returns memory data from consecutive addresses starting at `rx_base`.
- R10: An opcode in the range 0xB1 to 0xC8 inclusive produces exactly one single-cycle `cmd_valid` pulse, with `cmd_code` equal to the opcode, once the opcode byte is complete. Opcodes 0xB0 and 0xC9 produce none. Any bytes after a command opcode return 0x00.
- R11: Raising `csn` part way through a byte aborts the transaction. The partial byte is never written, and the next transaction starts again with the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI clock, idle low |
| csn | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| irq_pend | input | 1 | Interrupt-pending flag for the status byte |
| rc_ready | input | 1 | Controller-ready flag for the status byte |
| cca_clear | input | 1 | Channel-clear result for the status byte |
| rc_state | input | 4 | Controller state code for the status byte |
| tx_base | input | 10 | Start address for packet writes |
| rx_base | input | 10 | Start address for packet reads |
| cmd_valid | output | 1 | One-cycle pulse when a controller command arrives |
| cmd_code | output | 8 | Opcode of the last controller command |

## Verification
The bench checks read alignment. A design that fetches too early or too late places the data one byte off, so the fourth byte of a sequential read, or the third byte of a packet read, would hold zero or the neighbouring location.

It checks the ends of the command range, 0xB0/0xB1 and 0xC8/0xC9. A comparison that is off by one would drop a valid command or forward a stray one.

It writes across the 0x3FF boundary. A design that carries into a wider counter would write to the wrong location.

It drives the block-write variant and expects the neighbouring location to stay unchanged, which exposes a design that increments the address in that mode.

It also aborts a transaction in the middle of a data byte. A design that commits partial bytes, or that keeps its byte count across a chip-select cycle, would corrupt the stored byte or skip the status byte on the next transfer.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_SEQ_WR,
    K_SEQ_RD,
    K_BLK_WR,
    K_BLK_RD,
    K_PKT_WR,
    K_PKT_RD,
    K_CMD
  } op_kind_t;

  localparam logic [7:0] CMD_LO = 8'hB1;
  localparam logic [7:0] CMD_HI = 8'hC8;

  function automatic op_kind_t decode_op(input logic [7:0] op);
    op_kind_t k;
    k = K_NONE;
    if (op[7:2] == 6'b000110)      k = K_SEQ_WR;
    else if (op[7:2] == 6'b001110) k = K_SEQ_RD;
    else if (op[7:2] == 6'b000010) k = K_BLK_WR;
    else if (op[7:2] == 6'b001010) k = K_BLK_RD;
    else if (op == 8'h10)          k = K_PKT_WR;
    else if (op == 8'h30)          k = K_PKT_RD;
    else if (op >= CMD_LO && op <= CMD_HI) k = K_CMD;
    return k;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic csn,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_start,
  output logic mosi_s
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sck_q, csn_q, mosi_q;
  logic         sck_d, csn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      csn_q  <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sck_q  <= {sck_q[TOP-1:0], sck};
      csn_q  <= {csn_q[TOP-1:0], csn};
      mosi_q <= {mosi_q[TOP-1:0], mosi};
      sck_d  <= sck_q[TOP];
      csn_d  <= csn_q[TOP];
    end
  end

  assign cs_act   = ~csn_q[TOP];
  assign cs_start = csn_d & ~csn_q[TOP];
  assign sck_rise = cs_act & sck_q[TOP] & ~sck_d;
  assign sck_fall = cs_act & ~sck_q[TOP] & sck_d;
  assign mosi_s   = mosi_q[TOP];
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_act,
  input  logic         cs_start,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         mosi_s,
  input  logic [W-1:0] status_byte,
  input  logic [W-1:0] next_byte,
  output logic [W-1:0] rx_byte,
  output logic         byte_done,
  output logic         miso
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] bit_cnt;
  logic [W-1:0]  rx_sh, tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (cs_start) begin
        bit_cnt <= '0;
        tx_sh   <= status_byte;
      end else if (!cs_act) begin
        bit_cnt <= '0;
      end else begin
        if (sck_rise) begin
          rx_sh   <= {rx_sh[W-2:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CW'(W - 1)) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sh[W-2:0], mosi_s};
          end
        end
        if (sck_fall) begin
          if (bit_cnt == '0) tx_sh <= next_byte;
          else               tx_sh <= {tx_sh[W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso = tx_sh[W-1];
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int AW = 10,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_start,
  input  logic          byte_done,
  input  logic [W-1:0]  rx_byte,
  input  logic [AW-1:0] tx_base,
  input  logic [AW-1:0] rx_base,
  input  logic [W-1:0]  mem_rdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic [W-1:0]  next_byte,
  output logic          cmd_valid,
  output logic [W-1:0]  cmd_code
);
  localparam int HI = AW - W;

  op_kind_t      kind, dec;
  logic [1:0]    idx;
  logic [AW-1:0] addr;
  logic          rd_stage;
  logic          is_pkt, is_mem, is_wr, is_rd, bump, data_ph;

  assign dec = decode_op(rx_byte);

  always_comb begin
    is_pkt  = (kind == K_PKT_WR) || (kind == K_PKT_RD);
    is_mem  = (kind == K_SEQ_WR) || (kind == K_SEQ_RD) ||
              (kind == K_BLK_WR) || (kind == K_BLK_RD);
    is_wr   = (kind == K_SEQ_WR) || (kind == K_BLK_WR) || (kind == K_PKT_WR);
    is_rd   = (kind == K_SEQ_RD) || (kind == K_BLK_RD) || (kind == K_PKT_RD);
    bump    = is_pkt || (kind == K_SEQ_WR) || (kind == K_SEQ_RD);
    data_ph = (is_pkt && idx != 2'd0) || (is_mem && idx >= 2'd2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind      <= K_NONE;
      idx       <= '0;
      addr      <= '0;
      rd_stage  <= 1'b0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      next_byte <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
    end else begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      cmd_valid <= 1'b0;
      rd_stage  <= mem_re;
      if (cs_start) begin
        idx       <= '0;
        kind      <= K_NONE;
        next_byte <= '0;
      end else if (byte_done) begin
        next_byte <= '0;
        if (idx != 2'd3) idx <= idx + 1'b1;
        if (idx == 2'd0) begin
          kind <= dec;
          case (dec)
            K_PKT_WR: addr <= tx_base;
            K_PKT_RD: addr <= rx_base;
            K_CMD: begin
              cmd_valid <= 1'b1;
              cmd_code  <= rx_byte;
            end
            default: addr[AW-1:W] <= rx_byte[HI-1:0];
          endcase
        end else if (data_ph) begin
          mem_addr <= addr;
          if (is_wr) begin
            mem_we    <= 1'b1;
            mem_wdata <= rx_byte;
          end
          if (is_rd) mem_re <= 1'b1;
          if (bump) addr <= addr + 1'b1;
        end else if (is_mem && idx == 2'd1) begin
          addr[W-1:0] <= rx_byte;
        end
      end
      if (rd_stage) next_byte <= mem_rdata;
    end
  end
endmodule

// File: rtl/spi_byte_ram.sv
module spi_byte_ram #(
  parameter int AW = 10,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int AW          = 10,
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck,
  input  logic          csn,
  input  logic          mosi,
  output logic          miso,
  input  logic          irq_pend,
  input  logic          rc_ready,
  input  logic          cca_clear,
  input  logic [3:0]    rc_state,
  input  logic [AW-1:0] tx_base,
  input  logic [AW-1:0] rx_base,
  output logic          cmd_valid,
  output logic [W-1:0]  cmd_code
);
  logic          sck_rise, sck_fall, cs_act, cs_start, mosi_s;
  logic [W-1:0]  rx_byte, next_byte, status_byte, mem_rdata, mem_wdata;
  logic          byte_done, mem_we, mem_re;
  logic [AW-1:0] mem_addr;

  assign status_byte = W'({1'b1, irq_pend, rc_ready, cca_clear, rc_state});

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
    .cs_start(cs_start), .mosi_s(mosi_s)
  );

  spi_byte_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .cs_act(cs_act), .cs_start(cs_start),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .status_byte(status_byte), .next_byte(next_byte),
    .rx_byte(rx_byte), .byte_done(byte_done), .miso(miso)
  );

  spi_cmd_ctrl #(.AW(AW), .W(W)) u_ctrl (
    .clk(clk), .rst(rst), .cs_start(cs_start), .byte_done(byte_done),
    .rx_byte(rx_byte), .tx_base(tx_base), .rx_base(rx_base),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .next_byte(next_byte),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  spi_byte_ram #(.AW(AW), .W(W)) u_ram (
    .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cmd_valid,
  input logic [W-1:0] cmd_code,
  input logic         mem_we,
  input logic         mem_re,
  input logic         byte_done
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cmd_valid && !mem_we)); // R1

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid); // R10

  AST_CMD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_code >= 8'hB1 && cmd_code <= 8'hC8)); // R10

  AST_CMD_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(byte_done)); // R10

  AST_WE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(byte_done)); // R11

  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re)); // R4
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .mem_we(mem_we), .mem_re(mem_re), .byte_done(byte_done)
);

// File: tb/sim_spi_cmd_slave.sv
module sim_spi_cmd_slave;
  localparam int HALF = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic       miso;
  logic       irq_pend = 1'b0, rc_ready = 1'b0, cca_clear = 1'b0;
  logic [3:0] rc_state = 4'h0;
  logic [9:0] tx_base = '0, rx_base = '0;
  logic       cmd_valid;
  logic [7:0] cmd_code;

  int total = 0;
  int bad = 0;
  int cmd_cnt = 0;
  logic [7:0] last_cmd = 8'h00;
  logic [7:0] txb [16];
  logic [7:0] rxb [16];

  always #4 clk = ~clk;

  spi_cmd_slave u0 (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .mosi(mosi), .miso(miso),
    .irq_pend(irq_pend), .rc_ready(rc_ready), .cca_clear(cca_clear),
    .rc_state(rc_state), .tx_base(tx_base), .rx_base(rx_base),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  always @(posedge clk) begin
    if (!rst && cmd_valid) begin
      cmd_cnt  <= cmd_cnt + 1;
      last_cmd <= cmd_code;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - n; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_begin();
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic xact(input int n);
    logic [7:0] r;
    cs_begin();
    for (int i = 0; i < n; i++) begin
      spi_bits(txb[i], 8, r);
      rxb[i] = r;
    end
    cs_end();
  endtask

  task automatic t_reset();
    chk(miso == 1'b0, "R1 miso after reset", int'(miso), 0);
    chk(cmd_valid == 1'b0, "R1 cmd_valid after reset", int'(cmd_valid), 0);
  endtask

  task automatic t_status();
    irq_pend = 1; rc_ready = 0; cca_clear = 1; rc_state = 4'h4;
    txb[0] = 8'hFF; txb[1] = 8'hAB;
    xact(2);
    chk(rxb[0] == 8'hD4, "R2 status byte", rxb[0], 8'hD4);
    chk(rxb[1] == 8'h00, "R3 nop filler", rxb[1], 0);
    irq_pend = 0; rc_ready = 1; cca_clear = 0; rc_state = 4'h3;
    txb[0] = 8'hFF;
    xact(1);
    chk(rxb[0] == 8'hA3, "R2 status byte second pattern", rxb[0], 8'hA3);
  endtask

  task automatic t_seq();
    txb[0] = 8'h1A; txb[1] = 8'hA5; txb[2] = 8'h11; txb[3] = 8'h22; txb[4] = 8'h33;
    xact(5);
    txb[0] = 8'h3A; txb[1] = 8'hA5;
    for (int i = 2; i < 6; i++) txb[i] = 8'hFF;
    xact(6);
    chk(rxb[1] == 8'h00 && rxb[2] == 8'h00, "R5 address and dummy bytes zero",
        {rxb[1], rxb[2]}, 0);
    chk(rxb[3] == 8'h11, "R5 first read byte R4", rxb[3], 8'h11);
    chk(rxb[4] == 8'h22, "R4 increment R5", rxb[4], 8'h22);
    chk(rxb[5] == 8'h33, "R4 increment R5 third", rxb[5], 8'h33);
  endtask

  task automatic t_wrap();
    txb[0] = 8'h1B; txb[1] = 8'hFF; txb[2] = 8'h5A; txb[3] = 8'h6B;
    xact(4);
    txb[0] = 8'h38; txb[1] = 8'h00; txb[2] = 8'hFF; txb[3] = 8'hFF;
    xact(4);
    chk(rxb[3] == 8'h6B, "R6 wrap to 0x000", rxb[3], 8'h6B);
    txb[0] = 8'h3B; txb[1] = 8'hFF; txb[2] = 8'hFF; txb[3] = 8'hFF; txb[4] = 8'hFF;
    xact(5);
    chk(rxb[3] == 8'h5A && rxb[4] == 8'h6B, "R6 read across wrap",
        {rxb[3], rxb[4]}, 16'h5A6B);
  endtask

  task automatic t_block();
    txb[0] = 8'h19; txb[1] = 8'h00; txb[2] = 8'h01; txb[3] = 8'h02;
    xact(4);
    txb[0] = 8'h09; txb[1] = 8'h00; txb[2] = 8'hC3; txb[3] = 8'hD4;
    xact(4);
    txb[0] = 8'h39; txb[1] = 8'h00; txb[2] = 8'hFF; txb[3] = 8'hFF; txb[4] = 8'hFF;
    xact(5);
    chk(rxb[3] == 8'hD4, "R7 block write last byte lands", rxb[3], 8'hD4);
    chk(rxb[4] == 8'h02, "R7 block write neighbour untouched", rxb[4], 8'h02);
    txb[0] = 8'h29; txb[1] = 8'h00; txb[2] = 8'hFF; txb[3] = 8'hFF; txb[4] = 8'hFF;
    xact(5);
    chk(rxb[3] == 8'hD4 && rxb[4] == 8'hD4, "R7 block read repeats",
        {rxb[3], rxb[4]}, 16'hD4D4);
  endtask

  task automatic t_packet();
    tx_base = 10'h120;
    txb[0] = 8'h10; txb[1] = 8'hE1; txb[2] = 8'hE2; txb[3] = 8'hE3;
    xact(4);
    txb[0] = 8'h39; txb[1] = 8'h20;
    for (int i = 2; i < 6; i++) txb[i] = 8'hFF;
    xact(6);
    chk({rxb[3], rxb[4], rxb[5]} == 24'hE1E2E3, "R8 packet write at tx_base",
        {rxb[3], rxb[4], rxb[5]}, 24'hE1E2E3);
    rx_base = 10'h121;
    txb[0] = 8'h30; txb[1] = 8'hFF; txb[2] = 8'hFF; txb[3] = 8'hFF;
    xact(4);
    chk(rxb[1] == 8'h00, "R9 packet dummy byte", rxb[1], 0);
    chk(rxb[2] == 8'hE2 && rxb[3] == 8'hE3, "R9 packet read data",
        {rxb[2], rxb[3]}, 16'hE2E3);
  endtask

  task automatic t_cmd();
    int c0;
    c0 = cmd_cnt;
    txb[0] = 8'hB1;
    xact(1);
    chk(cmd_cnt == c0 + 1 && last_cmd == 8'hB1, "R10 lowest command", last_cmd, 8'hB1);
    txb[0] = 8'hC8;
    xact(1);
    chk(cmd_cnt == c0 + 2 && last_cmd == 8'hC8, "R10 highest command", cmd_cnt - c0, 2);
    txb[0] = 8'hB0;
    xact(1);
    txb[0] = 8'hC9;
    xact(1);
    chk(cmd_cnt == c0 + 2, "R10 out of range ignored", cmd_cnt - c0, 2);
    txb[0] = 8'hB7; txb[1] = 8'hFF;
    xact(2);
    chk(cmd_cnt == c0 + 3 && last_cmd == 8'hB7, "R10 command with trailer",
        last_cmd, 8'hB7);
    chk(rxb[1] == 8'h00, "R10 trailer returns zero", rxb[1], 0);
  endtask

  task automatic t_unknown();
    int c0;
    c0 = cmd_cnt;
    txb[0] = 8'h55; txb[1] = 8'h12; txb[2] = 8'h34;
    xact(3);
    chk(rxb[1] == 8'h00 && rxb[2] == 8'h00, "R3 unknown opcode returns zero",
        {rxb[1], rxb[2]}, 0);
    chk(cmd_cnt == c0, "R3 unknown opcode no command", cmd_cnt - c0, 0);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    txb[0] = 8'h1A; txb[1] = 8'h50; txb[2] = 8'h77;
    xact(3);
    cs_begin();
    spi_bits(8'h1A, 8, r);
    spi_bits(8'h50, 8, r);
    spi_bits(8'h99, 4, r);
    cs_end();
    irq_pend = 0; rc_ready = 1; cca_clear = 1; rc_state = 4'h5;
    txb[0] = 8'h3A; txb[1] = 8'h50; txb[2] = 8'hFF; txb[3] = 8'hFF;
    xact(4);
    chk(rxb[0] == 8'hB5, "R11 status after abort", rxb[0], 8'hB5);
    chk(rxb[3] == 8'h77, "R11 partial byte not written", rxb[3], 8'h77);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_status();
    t_seq();
    t_wrap();
    t_block();
    t_packet();
    t_cmd();
    t_unknown();
    t_abort();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule